// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits over several clock cycles and returns a signed product of twice that width. It uses radix-2 Booth recoding. The multiplier operand sits in a shift register, and a one-bit history flag sits to the right of that register's least significant bit. On each step the block looks at that bit pair. It then adds the multiplicand to the upper half of the product, subtracts it, or leaves the upper half alone. Last, it shifts the whole working word one place right while keeping the sign.

A client raises `start` for one cycle while the block is idle and presents both operands in that cycle. The block stays busy for `WIDTH` steps. It then pulses `done` and keeps the product on its output until the next accepted start. Negative operands need no sign correction before or after the run.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is held, and in the cycles after it until a start is accepted, `busy` and `done` are 0 and `product` is all zeros.
- R2: If `start` is 1 at a clock edge while `busy` is 0, the block captures `multiplier` and `multiplicand` at that edge, and `busy` reads 1 in the following cycle.
- R3: Call the accepting edge k. `done` stays 0 after edges k+1 through k+WIDTH-1 and reads 1 after edge k+WIDTH. `busy` falls at that same edge.
- R4: `done` is high for exactly one cycle per operation.
- R5: When `done` is 1, `product` equals the signed product of `multiplier` and `multiplicand` as a 2·WIDTH-bit two's-complement value. This holds for every sign combination of the operands.
- R6: Multiplying the most negative operand by itself gives +2^(2·WIDTH-2). For WIDTH=8 that is 16'h4000. An N-bit overflow of the add or subtract must not flip the sign shifted into the product.
- R7: A `start` raised while `busy` is 1 is ignored. The running operation keeps its original operands and its `done` timing.
- R8: After `done`, `product` holds its value until the next accepted start, and `done` stays 0.
- R9: A `start` raised in the same cycle that `done` is 1 is accepted and begins a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Launch request, sampled while idle |
| multiplicand | input | WIDTH | Signed multiplicand, captured on an accepted start |
| multiplier | input | WIDTH | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while recoding steps are running |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product; holds its value between operations |

## Verification
Two functions can land in the same cycle. One is the completion pulse of a run. The other is the acceptance of a new request, since `busy` has already fallen while `done` is high. The bench raises `start` with fresh operands exactly in the `done` cycle. It then checks two things: that the first product was correct in that cycle, and that a complete second run with the second operands follows after exactly WIDTH steps. A second overlap is also tested: a request that arrives partway through a run. For that case the bench checks that the final product still matches the original operands.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // Recoded action for one radix-2 Booth step
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } booth_act_e;

  function automatic booth_act_e decode_pair(input logic q0, input logic qprev);
    case ({q0, qprev})
      2'b01:   return ACT_ADD;
      2'b10:   return ACT_SUB;
      default: return ACT_HOLD;
    endcase
  endfunction
endpackage

// File: rtl/booth_rst_sync.sv
module booth_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] mq_i,
  input  logic             prev_i,
  input  logic [WIDTH-1:0] mcand_i,
  output logic [WIDTH-1:0] acc_o,
  output logic [WIDTH-1:0] mq_o,
  output logic             prev_o
);
  localparam int XW = WIDTH + 1;

  booth_act_e     act;
  logic [XW-1:0]  acc_x;
  logic [XW-1:0]  mcand_x;
  logic [XW-1:0]  sum_x;

  always_comb begin
    act     = decode_pair(mq_i[0], prev_i);
    acc_x   = {acc_i[WIDTH-1], acc_i};
    mcand_x = {mcand_i[WIDTH-1], mcand_i};
    case (act)
      ACT_ADD: sum_x = acc_x + mcand_x;
      ACT_SUB: sum_x = acc_x - mcand_x;
      default: sum_x = acc_x;
    endcase
    // arithmetic shift: the exact sign of the widened sum enters the top
    acc_o  = sum_x[XW-1:1];
    mq_o   = {sum_x[0], mq_i[WIDTH-1:1]};
    prev_o = mq_i[0];
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign load = start && !busy_q;
  assign step = busy_q;
  assign last = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (step) begin
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R3
  done_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic rst_n_s;
  logic load, step;

  logic [WIDTH-1:0] acc_q, acc_d, acc_nx;
  logic [WIDTH-1:0] mq_q, mq_d, mq_nx;
  logic [WIDTH-1:0] mc_q, mc_d;
  logic             prev_q, prev_d, prev_nx;

  booth_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n_s),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  booth_step #(.WIDTH(WIDTH)) u_step (
    .acc_i   (acc_q),
    .mq_i    (mq_q),
    .prev_i  (prev_q),
    .mcand_i (mc_q),
    .acc_o   (acc_nx),
    .mq_o    (mq_nx),
    .prev_o  (prev_nx)
  );

  always_comb begin
    acc_d  = acc_q;
    mq_d   = mq_q;
    mc_d   = mc_q;
    prev_d = prev_q;
    if (load) begin
      acc_d  = '0;
      mq_d   = multiplier;
      mc_d   = multiplicand;
      prev_d = 1'b0;
    end else if (step) begin
      acc_d  = acc_nx;
      mq_d   = mq_nx;
      prev_d = prev_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      acc_q  <= '0;
      mq_q   <= '0;
      mc_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      mq_q   <= mq_d;
      mc_q   <= mc_d;
      prev_q <= prev_d;
    end
  end

  assign product = {acc_q, mq_q};

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && start) |=> $stable(mc_q));
  // R8
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && !start) |=> $stable(product));
  // R2
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && !busy) |=> (acc_q == '0));
endmodule

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;
  localparam int W  = 8;
  localparam int NV = 12;
  localparam logic [2*W-1:0] VEC [NV] = '{
    {8'h03, 8'h05}, {8'hFD, 8'h05}, {8'h07, 8'hF9}, {8'hF6, 8'hF6},
    {8'h7F, 8'h7F}, {8'h80, 8'h7F}, {8'h7F, 8'h80}, {8'h00, 8'h55},
    {8'h01, 8'h80}, {8'hFF, 8'hFF}, {8'hAA, 8'h55}, {8'hC3, 8'h3C}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mc = '0;
  logic [W-1:0]   mp = '0;
  logic           busy, done;
  logic [2*W-1:0] prod;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  booth_seq_mult #(.WIDTH(W)) uut (
    .clk (clk), .rst_n (rst_n), .start (start),
    .multiplicand (mc), .multiplier (mp),
    .busy (busy), .done (done), .product (prod)
  );

  function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] r;
    r = $signed(a) * $signed(b);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Raise start for one edge; returns at the negedge after the accepting edge
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    mp = a; mc = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", 32'(busy), 32'd1);
  endtask

  // Walk WIDTH edges; optionally poke start mid-run; ends in done cycle
  task automatic finish_run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke, input string tag);
    bit early = 1'b0;
    for (int i = 1; i < W; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (done) early = 1'b1;
      if (poke && i == 2) begin
        start = 1'b1; mp = 8'h11; mc = 8'h22;
      end else begin
        start = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(!early, "R3 done not early", 32'(early), 32'd0);
    chk(done === 1'b1, "R3 done after WIDTH steps", 32'(done), 32'd1);
    chk(busy === 1'b0, "R3 busy falls with done", 32'(busy), 32'd0);
    chk(prod === ref_prod(a, b), tag, 32'(prod), 32'(ref_prod(a, b)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [2*W-1:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 flags in reset", {busy, done}, 0);
    chk(prod === '0, "R1 product in reset", 32'(prod), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && prod === '0, "R1 state after reset", {busy, done, prod}, 0);

    // R5: table of vectors
    for (int v = 0; v < NV; v++) begin
      launch(VEC[v][2*W-1:W], VEC[v][W-1:0]);
      finish_run(VEC[v][2*W-1:W], VEC[v][W-1:0], 1'b0, "R5 signed product");
      @(posedge clk);
      @(negedge clk);
      chk(done === 1'b0, "R4 done one cycle", 32'(done), 0);
    end

    // R6: most negative squared
    launch(8'h80, 8'h80);
    finish_run(8'h80, 8'h80, 1'b0, "R6 most negative squared");
    chk(prod === 16'h4000, "R6 exact value", 32'(prod), 32'h4000);

    // R8: hold after done
    held = prod;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(prod === held, "R8 product held", 32'(prod), 32'(held));
    chk(done === 1'b0, "R8 done stays low", 32'(done), 0);

    // R7: start during run ignored
    launch(8'hE5, 8'h13);
    finish_run(8'hE5, 8'h13, 1'b1, "R7 start while busy ignored");

    // R9: start in the done cycle starts a new run
    mp = 8'h9C; mc = 8'hD7; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R9 accepted in done cycle", 32'(busy), 1);
    chk(done === 1'b0, "R9 done cleared", 32'(done), 0);
    finish_run(8'h9C, 8'hD7, 1'b0, "R9 back-to-back product");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule